// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable slave on a two-wire serial bus (I2C) that behaves like a small serial EEPROM of 256 bytes. The system clock samples both bus lines. The block finds START and STOP conditions and decodes the select byte. It then carries out single-byte writes, page writes, reads at the stored pointer, random reads and sequential reads on an internal byte array. The block never drives the data line high: it only asks for the line to be pulled low, and the pad logic turns that request into open-drain drive.

Written bytes are first collected in a buffer the size of one page. They reach the array only when the master sends STOP. A write-inhibit input blocks every change to the array. A programmable down-counter stands in for the self-timed programming time. While it runs, the busy flag is high and the slave ignores its own select byte.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: After reset, `sda_low_o` and `busy_o` are both 0.
- R2: The slave acknowledges a select byte only when bits 7..4 equal 1010 and bits 3..1 equal `addr_strap[2:0]`. Bit 0 selects the direction (0 = write, 1 = read). Any other select byte gets no acknowledge, and the slave keeps SDA released until the next START.
- R3: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A repeated START restarts byte decoding and throws away the data bytes buffered since the last START, so nothing is committed.
- R4: After each byte the master writes (select, word address, data), the slave pulls SDA low for the whole ninth clock whenever it accepts that byte.
- R5: In a write, the byte after the select byte is the word address and the following bytes are data. The data reaches the array only on STOP, and a later read returns it.
- R6: A page is 16 bytes, with address bits 7..4 as the page and bits 3..0 as the column. Data bytes in one write advance the column only. A write longer than the page wraps to column 0 of the same page, and a later byte at a column replaces the earlier one.
- R7: While `wr_inhibit` is 1, the select and word-address bytes are still acknowledged. Data bytes are not acknowledged, and the array stays unchanged.
- R8: A commit sets `busy_o` to 1 for `BUSY_CYCLES` clocks. While it is 1, the select byte is not acknowledged.
- R9: Random read: a write select byte, then a word address, then a repeated START with a read select byte. This returns the byte at that address.
- R10: Each byte read moves the pointer by one, wrapping from 0xFF to 0x00. A read without a word address starts at the stored pointer.
- R11: During a read, the slave changes SDA only while SCL is low. It releases SDA on the master's acknowledge slot, and after a no-acknowledge it stops driving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| addr_strap | input | 3 | Strap value compared with select-byte bits 3..1 |
| wr_inhibit | input | 1 | When 1, the array cannot be modified |
| sda_low_o | output | 1 | 1 asks the pad to pull SDA low |
| busy_o | output | 1 | Programming time in progress |

## Verification
The assertions assume that the master moves SDA only while SCL is low, except for START and STOP. They also assume that each SCL high or low phase lasts several system clocks, longer than the three-stage sampling path, and that the strap and inhibit inputs do not change in the middle of a byte. The bench drives the bus with six system clocks per quarter bit and changes master data only in the low phase. It holds the strap constant and changes the inhibit input only between transfers. Under these conditions the SDA-hold property and the per-clock monitor of the slave's drive compare against a settled clock level.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int         DEPTH       = 256,
  parameter int         PAGE_BYTES  = 16,
  parameter int         BUSY_CYCLES = 1000,
  parameter logic [3:0] TYPE_CODE   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] addr_strap,
  input  logic       wr_inhibit,
  output logic       sda_low_o,
  output logic       busy_o
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = $clog2(PAGE_BYTES);
  localparam int BCW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_DEV, ST_ADDR, ST_WDATA, ST_RDATA} state_t;

  logic [2:0] scl_pipe, sda_pipe;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       start_c, stop_c, rise, fall, frame_end, dev_hit;

  state_t                 state;
  logic [3:0]             bitcnt;
  logic                   ninth, mack;
  logic [7:0]             shreg;
  logic [AW-1:0]          ptr;
  logic [AW-CW-1:0]       page_base;
  logic [7:0]             buf_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  buf_vld;
  logic [BCW-1:0]         busy_cnt;
  logic [7:0]             mem [DEPTH];

  assign scl_s = scl_pipe[1];
  assign scl_q = scl_pipe[2];
  assign sda_s = sda_pipe[1];
  assign sda_q = sda_pipe[2];

  assign start_c   = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c    = scl_s & scl_q & ~sda_q & sda_s;
  assign rise      = scl_s & ~scl_q;
  assign fall      = ~scl_s & scl_q;
  assign frame_end = fall && bitcnt == 4'd8 && !ninth;
  assign dev_hit   = shreg[7:4] == TYPE_CODE && shreg[3:1] == addr_strap && busy_cnt == '0;
  assign busy_o    = busy_cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= 3'b111;
      sda_pipe <= 3'b111;
    end else begin
      scl_pipe <= {scl_pipe[1:0], scl_i};
      sda_pipe <= {sda_pipe[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      ninth     <= 1'b0;
      mack      <= 1'b0;
      shreg     <= '0;
      ptr       <= '0;
      page_base <= '0;
      buf_vld   <= '0;
      busy_cnt  <= '0;
      sda_low_o <= 1'b0;
      for (int i = 0; i < PAGE_BYTES; i++) buf_data[i] <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (start_c) begin
        state     <= ST_DEV;
        bitcnt    <= '0;
        ninth     <= 1'b0;
        sda_low_o <= 1'b0;
        buf_vld   <= '0;
      end else if (stop_c) begin
        state     <= ST_IDLE;
        sda_low_o <= 1'b0;
        buf_vld   <= '0;
        if (|buf_vld && !wr_inhibit) begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (buf_vld[i]) mem[{page_base, CW'(i)}] <= buf_data[i];
          busy_cnt <= BCW'(BUSY_CYCLES);
        end
      end else if (state != ST_IDLE) begin
        if (rise) begin
          if (bitcnt != 4'd8) begin
            bitcnt <= bitcnt + 4'd1;
            if (state != ST_RDATA) shreg <= {shreg[6:0], sda_s};
          end else begin
            ninth <= 1'b1;
            // low line in the ninth slot: our own ack, or the master's ack on a read
            mack  <= ~sda_s;
          end
        end else if (fall) begin
          if (ninth) begin
            ninth     <= 1'b0;
            bitcnt    <= '0;
            sda_low_o <= 1'b0;
            if (state == ST_RDATA) begin
              if (mack) begin
                shreg     <= mem[ptr];
                sda_low_o <= ~mem[ptr][7];
                ptr       <= ptr + 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end else if (bitcnt == 4'd8) begin
            case (state)
              ST_DEV: begin
                if (dev_hit) begin
                  sda_low_o <= 1'b1;
                  state     <= shreg[0] ? ST_RDATA : ST_ADDR;
                end else begin
                  state <= ST_IDLE;
                end
              end
              ST_ADDR: begin
                sda_low_o <= 1'b1;
                ptr       <= shreg[AW-1:0];
                page_base <= shreg[AW-1:CW];
                state     <= ST_WDATA;
              end
              ST_WDATA: begin
                if (!wr_inhibit) begin
                  sda_low_o            <= 1'b1;
                  buf_data[ptr[CW-1:0]] <= shreg;
                  buf_vld[ptr[CW-1:0]]  <= 1'b1;
                  ptr[CW-1:0]          <= ptr[CW-1:0] + 1'b1;
                end
              end
              default: sda_low_o <= 1'b0;
            endcase
          end else if (state == ST_RDATA && bitcnt != '0) begin
            sda_low_o <= ~shreg[6];
            shreg     <= {shreg[6:0], 1'b0};
          end
        end
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) $rose(rst_n) |-> !sda_low_o && !busy_o);

  p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_low_o);

  p_sda_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_q && !start_c && !stop_c) |=> $stable(sda_low_o));

  p_lock_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WDATA && frame_end && wr_inhibit) |=> !sda_low_o);

  p_busy_nack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DEV && frame_end && busy_o) |=> !sda_low_o);

  p_busy_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_c));

  p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WDATA |=> ptr[AW-1:CW] == $past(ptr[AW-1:CW]));
endmodule

// File: tb/test_eeprom_i2c_slave.sv
module test_eeprom_i2c_slave;
  localparam int BUSY = 300;
  localparam int Q    = 6;
  localparam logic [7:0] SEL_W = 8'hAA;
  localparam logic [7:0] SEL_R = 8'hAB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wr_inhibit = 1'b0;
  logic [2:0] addr_strap = 3'b101;
  logic sda_low_o, busy_o;
  logic sda_line;
  int checks = 0, failures = 0, hi_run = 0, mon_err = 0;
  logic prev_low = 1'b0;
  logic [7:0] model [256];

  assign sda_line = sda_m & ~sda_low_o;

  always #2 clk = ~clk;

  eeprom_i2c_slave #(.BUSY_CYCLES(BUSY)) i_eeprom_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_strap(addr_strap), .wr_inhibit(wr_inhibit),
    .sda_low_o(sda_low_o), .busy_o(busy_o));

  // per-clock reference for R11: drive must hold while SCL has settled high
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_m) hi_run++; else hi_run = 0;
      if (hi_run >= 5 && sda_low_o != prev_low) mon_err++;
    end
    prev_low = sda_low_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq; scl_m = 1'b1; wq; b = sda_line; wq; scl_m = 1'b0; wq;
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(~give_ack);
  endtask

  task automatic wait_busy;
    repeat (BUSY + 20) @(negedge clk);
  endtask

  task automatic write_run(input logic [7:0] addr, input int n, input logic [7:0] base);
    logic a;
    bus_start;
    write_byte(SEL_W, a); chk("R4 select ack", a, 1);
    write_byte(addr, a);  chk("R4 address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      write_byte(base + 8'(k), a);
      chk("R4 data ack", a, 1);
      model[{addr[7:4], 4'(addr[3:0] + 4'(k))}] = base + 8'(k);
    end
    bus_stop;
  endtask

  task automatic read_run(input logic [7:0] addr, input int n, input string req);
    logic a;
    logic [7:0] d;
    bus_start;
    write_byte(SEL_W, a);
    write_byte(addr, a);
    bus_start;
    write_byte(SEL_R, a); chk("R9 read select ack", a, 1);
    for (int k = 0; k < n; k++) begin
      read_byte(k < n - 1, d);
      chk(req, d, model[8'(addr + 8'(k))]);
    end
    repeat (4) @(negedge clk);
    chk("R11 released after no-ack", sda_low_o, 0);
    bus_stop;
  endtask

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sda after reset", sda_low_o, 0);
    chk("R1 busy after reset", busy_o, 0);
    wq;

    // R2: wrong strap bits and wrong type code
    bus_start; write_byte(8'hA0, a); chk("R2 strap mismatch nack", a, 0);
    send_bit(1'b1); chk("R2 released after mismatch", sda_low_o, 0); bus_stop;
    bus_start; write_byte(8'hBA, a); chk("R2 type mismatch nack", a, 0); bus_stop;

    // R5 byte write, R8 busy window
    write_run(8'h10, 1, 8'h5C);
    repeat (10) @(negedge clk);
    chk("R8 busy after commit", busy_o, 1);
    bus_start; write_byte(SEL_W, a); chk("R8 select nack while busy", a, 0); bus_stop;
    wait_busy;
    chk("R8 busy ends", busy_o, 0);
    read_run(8'h10, 1, "R5 byte write readback");

    // R6 page write with wrap, R10 sequential read
    write_run(8'h2E, 20, 8'h80);
    wait_busy;
    read_run(8'h20, 16, "R6 page wrap readback");

    // R7 write inhibit
    wr_inhibit = 1'b1;
    bus_start;
    write_byte(SEL_W, a); chk("R7 select ack when inhibited", a, 1);
    write_byte(8'h10, a); chk("R7 address ack when inhibited", a, 1);
    write_byte(8'h11, a); chk("R7 data nack when inhibited", a, 0);
    bus_stop;
    repeat (10) @(negedge clk);
    chk("R7 no programming when inhibited", busy_o, 0);
    wr_inhibit = 1'b0;
    read_run(8'h10, 1, "R7 array unchanged");

    // R3 repeated start discards buffered data
    bus_start;
    write_byte(SEL_W, a); write_byte(8'h40, a); write_byte(8'h77, a);
    bus_start;
    write_byte(SEL_R, a); chk("R3 read select after repeated start", a, 1);
    read_byte(1'b0, d); chk("R3 current read after discard", d, model[8'h41]);
    bus_stop;
    repeat (10) @(negedge clk);
    chk("R3 no commit after repeated start", busy_o, 0);
    read_run(8'h40, 1, "R3 discarded byte absent");

    // R10 wrap 0xFF -> 0x00 and current-address read
    write_run(8'hFF, 1, 8'h3C); wait_busy;
    write_run(8'h00, 1, 8'h4D); wait_busy;
    read_run(8'hFF, 2, "R10 sequential wrap");
    bus_start;
    write_byte(SEL_R, a); chk("R10 current read select ack", a, 1);
    read_byte(1'b0, d); chk("R10 current address read", d, model[8'h01]);
    bus_stop;

    chk("R11 drive changed only with SCL low", mon_err, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule